// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Unit

This block hands the core one instruction per request. The core supplies a fetch address and a flag that says whether compressed instructions are in use. For an ordinary fetch, the unit looks in a direct-mapped instruction cache. A hit answers on the next cycle without touching memory. A miss sends the fetch address to the memory side, which translates it and returns a 32-bit word. The unit forwards that word and also writes it into the cache line.

A fetch whose address is two bytes past a word boundary, made while compressed mode is on, goes around the cache. The unit first asks memory for the halfword at the fetch address. If that halfword's length bits mark a 16-bit instruction, the unit answers at once. If not, the unit makes a second, separate request for the halfword at the fetch address plus two. It then joins the two halves. This path never reads the cache and never writes it.

Either translation may fault. A fault is returned in place of the instruction.

Top module: `insn_fetch_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R2: An accepted cache-path request whose exact full address is in a valid line responds one cycle after acceptance with the stored word, and makes no memory request.
- R3: A cache-path miss requests a word (`mem_half_o`=0) at the fetch address. It responds with the returned 32 bits and overwrites the tag and data of line `addr[9:2]`. Addresses 1024 bytes apart therefore evict each other.
- R4: The split path is taken only when `req_cmode_i`=1 and `req_addr_i[1:0]`=2'b10. Every other request, including offset 2 with compressed mode off, uses the cache.
- R5: On the split path, the first request is a halfword read (`mem_half_o`=1) at the fetch address, whose data comes back in bits 15:0. If bits 1:0 of that halfword are not 2'b11, the response is {16'h0, halfword} after that single read.
- R6: If the first halfword's bits 1:0 are 2'b11, a second halfword read is made at the fetch address plus 2. The response is {second halfword, first halfword}.
- R7: A split-path fetch leaves the cache untouched, so a later cache-path request for the same address misses.
- R8: A fault on any memory response ends the request with `rsp_fault_o`=1 and `rsp_insn_o`=0, and fills nothing. A fault on the first halfword prevents the second read.
- R9: `flush_i` invalidates every line in one cycle. A lookup made in the same cycle misses, and each address misses again until it is refilled.
- R10: While a memory request is outstanding, `mem_req_o` stays high with a stable address and size until `mem_rsp_valid_i`. During that time `req_ready_o` is 0.
- R11: Each accepted request yields exactly one single-cycle `rsp_valid_o` pulse, and the unit is ready again in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Fetch request strobe |
| req_addr_i | input | ADDR_W | Fetch address |
| req_cmode_i | input | 1 | Compressed mode enabled |
| flush_i | input | 1 | Invalidate whole cache |
| req_ready_o | output | 1 | Unit idle, request accepted |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_insn_o | output | 32 | Instruction bits (0 on fault) |
| rsp_fault_o | output | 1 | Translation fault |
| mem_req_o | output | 1 | Translate-and-read request, held until answered |
| mem_addr_o | output | ADDR_W | Virtual address to translate |
| mem_half_o | output | 1 | 1 = halfword read, 0 = word read |
| mem_rsp_valid_i | input | 1 | Memory response strobe |
| mem_rsp_data_i | input | 32 | Read data (halfword in bits 15:0) |
| mem_rsp_fault_i | input | 1 | Translation fault on this response |

## Verification
The hardest case to reach is a split fetch whose second translation faults after the first one succeeded. That needs an offset-2 address whose first halfword carries the 32-bit length code and whose next halfword lies in a faulting region. The bench memory model defines both length codes and fault regions as functions of the address. The vector table can then name such an address, 0xBFE, directly.

Proving that the split path does not fill the cache is also indirect. A cache-path fetch of the same address follows, and the bench counts memory reads and measures response latency. Proving that a hit is served from the cache works the same way: the model's memory contents are altered, and a hit must still return the old word.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
    localparam int INSN_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WORD = 2'd1,
        ST_LO   = 2'd2,
        ST_HI   = 2'd3
    } fetch_st_e;
endpackage

// File: rtl/ifu_len_check.sv
module ifu_len_check (
    input  logic [1:0] low_bits_i,
    output logic       wide_o
);
    // 2'b11 in the lowest bits marks a 32-bit encoding
    always_comb begin
        wide_o = (low_bits_i == 2'b11);
    end
endmodule

// File: rtl/ifu_icache.sv
module ifu_icache #(
    parameter int ADDR_W = 32,
    parameter int LINES  = 256,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lkp_addr_i,
    output logic              lkp_hit_o,
    output logic [DATA_W-1:0] lkp_data_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              flush_i
);
    localparam int IDX_W = $clog2(LINES);

    logic [LINES-1:0]  valid_q;
    logic [ADDR_W-1:0] tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    logic [IDX_W-1:0] lkp_idx;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        lkp_idx    = lkp_addr_i[IDX_W+1:2];
        wr_idx     = wr_addr_i[IDX_W+1:2];
        lkp_hit_o  = valid_q[lkp_idx] && (tag_q[lkp_idx] == lkp_addr_i) && !flush_i;
        lkp_data_o = data_q[lkp_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
        end else if (wr_en_i) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i && !flush_i) begin
            tag_q[wr_idx]  <= wr_addr_i;
            data_q[wr_idx] <= wr_data_i;
        end
    end
endmodule

// File: rtl/insn_fetch_unit.sv
module insn_fetch_unit #(
    parameter int ADDR_W = 32,
    parameter int LINES  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_cmode_i,
    input  logic              flush_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_insn_o,
    output logic              rsp_fault_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_half_o,
    input  logic              mem_rsp_valid_i,
    input  logic [31:0]       mem_rsp_data_i,
    input  logic              mem_rsp_fault_i
);
    import ifu_pkg::*;

    typedef struct packed {
        fetch_st_e         st;
        logic [ADDR_W-1:0] addr;
        logic [HALF_W-1:0] lo;
        logic              rsp_v;
        logic              rsp_f;
        logic [INSN_W-1:0] rsp_d;
    } ctl_t;

    localparam ctl_t CTL_RST = '0;

    ctl_t d, q;

    logic              hit;
    logic [INSN_W-1:0] hit_data;
    logic              fill_en;
    logic              first_wide;
    logic              is_split;

    ifu_icache #(
        .ADDR_W (ADDR_W),
        .LINES  (LINES),
        .DATA_W (INSN_W)
    ) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .lkp_addr_i (req_addr_i),
        .lkp_hit_o  (hit),
        .lkp_data_o (hit_data),
        .wr_en_i    (fill_en),
        .wr_addr_i  (q.addr),
        .wr_data_i  (mem_rsp_data_i),
        .flush_i    (flush_i)
    );

    ifu_len_check u_len (
        .low_bits_i (mem_rsp_data_i[1:0]),
        .wide_o     (first_wide)
    );

    always_comb begin
        d        = q;
        d.rsp_v  = 1'b0;
        d.rsp_f  = 1'b0;
        d.rsp_d  = '0;
        fill_en  = 1'b0;
        is_split = req_cmode_i && (req_addr_i[1:0] == 2'b10);

        case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.addr = req_addr_i;
                    if (is_split) begin
                        d.st = ST_LO;
                    end else if (hit) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = hit_data;
                    end else begin
                        d.st = ST_WORD;
                    end
                end
            end
            ST_WORD: begin
                if (mem_rsp_valid_i) begin
                    d.st    = ST_IDLE;
                    d.rsp_v = 1'b1;
                    if (mem_rsp_fault_i) begin
                        d.rsp_f = 1'b1;
                    end else begin
                        d.rsp_d = mem_rsp_data_i;
                        fill_en = 1'b1;
                    end
                end
            end
            ST_LO: begin
                if (mem_rsp_valid_i) begin
                    if (mem_rsp_fault_i) begin
                        d.st    = ST_IDLE;
                        d.rsp_v = 1'b1;
                        d.rsp_f = 1'b1;
                    end else if (!first_wide) begin
                        d.st    = ST_IDLE;
                        d.rsp_v = 1'b1;
                        d.rsp_d = {{(INSN_W-HALF_W){1'b0}}, mem_rsp_data_i[HALF_W-1:0]};
                    end else begin
                        d.lo   = mem_rsp_data_i[HALF_W-1:0];
                        d.addr = q.addr + ADDR_W'(2);
                        d.st   = ST_HI;
                    end
                end
            end
            ST_HI: begin
                if (mem_rsp_valid_i) begin
                    d.st    = ST_IDLE;
                    d.rsp_v = 1'b1;
                    if (mem_rsp_fault_i) begin
                        d.rsp_f = 1'b1;
                    end else begin
                        d.rsp_d = {mem_rsp_data_i[HALF_W-1:0], q.lo};
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready_o = (q.st == ST_IDLE);
        rsp_valid_o = q.rsp_v;
        rsp_insn_o  = q.rsp_d;
        rsp_fault_o = q.rsp_f;
        mem_req_o   = (q.st != ST_IDLE);
        mem_addr_o  = q.addr;
        mem_half_o  = (q.st == ST_LO) || (q.st == ST_HI);
    end
endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              req_cmode_i,
    input logic              flush_i,
    input logic              req_ready_o,
    input logic              rsp_valid_o,
    input logic [31:0]       rsp_insn_o,
    input logic              rsp_fault_o,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_half_o,
    input logic              mem_rsp_valid_i,
    input logic [1:0]        mem_rsp_low_i,
    input logic              mem_rsp_fault_i
);
    logic accept;
    logic split_req;
    always_comb begin
        accept    = req_valid_i && req_ready_o;
        split_req = req_cmode_i && (req_addr_i[1:0] == 2'b10);
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_rsp_valid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_half_o));

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_ready_o);

    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> req_ready_o && !mem_req_o);

    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_fault_o |-> rsp_insn_o == 32'h0);

    // R4
    split_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && split_req |=> mem_req_o && mem_half_o && mem_addr_o == $past(req_addr_i));

    // R3
    word_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !split_req |=> rsp_valid_o || (mem_req_o && !mem_half_o && mem_addr_o == $past(req_addr_i)));

    // R9
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !split_req && flush_i |=> mem_req_o);

    // R5
    short_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid_i && mem_half_o && mem_rsp_low_i != 2'b11 |=> rsp_valid_o);

    // R6
    upper_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid_i && mem_half_o && !mem_rsp_fault_i && mem_rsp_low_i == 2'b11
        |=> rsp_valid_o || (mem_req_o && mem_half_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)));
endmodule

bind insn_fetch_unit ifu_fetch_chk #(.ADDR_W(ADDR_W)) u_fetch_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid_i     (req_valid_i),
    .req_addr_i      (req_addr_i),
    .req_cmode_i     (req_cmode_i),
    .flush_i         (flush_i),
    .req_ready_o     (req_ready_o),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_insn_o      (rsp_insn_o),
    .rsp_fault_o     (rsp_fault_o),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .mem_half_o      (mem_half_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_low_i   (mem_rsp_data_i[1:0]),
    .mem_rsp_fault_i (mem_rsp_fault_i)
);

// File: tb/test_insn_fetch_unit.sv
module test_insn_fetch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int AW         = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic          req_cmode_i = 1'b0;
    logic          flush_i = 1'b0;
    logic          req_ready_o;
    logic          rsp_valid_o;
    logic [31:0]   rsp_insn_o;
    logic          rsp_fault_o;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_half_o;
    logic          mem_rsp_valid_i = 1'b0;
    logic [31:0]   mem_rsp_data_i = '0;
    logic          mem_rsp_fault_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int reads = 0;
    int cnt = 0;
    logic [13:0] salt = '0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_fetch_unit #(.ADDR_W(AW), .LINES(256)) i_insn_fetch_unit (.*);

    function automatic logic [15:0] hw(input logic [31:0] a);
        logic [1:0] lb;
        lb = (a[5:4] == 2'b01) ? 2'b01 : 2'b11;
        return {a[15:2] ^ 14'h1A5 ^ salt, lb};
    endfunction

    function automatic logic [31:0] wd(input logic [31:0] a);
        return {hw(a + 32'd2), hw(a)};
    endfunction

    function automatic logic flt(input logic [31:0] a);
        return a[11:8] == 4'hC;
    endfunction

    // memory model: answers LAT negedges after the request is seen
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid_i <= 1'b0;
            cnt <= 0;
        end else if (mem_rsp_valid_i) begin
            mem_rsp_valid_i <= 1'b0;
            cnt <= 0;
        end else if (mem_req_o) begin
            if (cnt == LAT) begin
                mem_rsp_valid_i <= 1'b1;
                mem_rsp_fault_i <= flt(mem_addr_o);
                mem_rsp_data_i  <= mem_half_o ? {16'h0, hw(mem_addr_o)} : wd(mem_addr_o);
                reads <= reads + 1;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] a, input logic cm, input logic fl,
                         output logic [31:0] insn, output logic f, output int cyc, output int nrd);
        int r0;
        logic busy_bad;
        @(negedge clk);
        r0 = reads;
        req_valid_i = 1'b1;
        req_addr_i  = a;
        req_cmode_i = cm;
        flush_i     = fl;
        busy_bad    = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            req_valid_i = 1'b0;
            flush_i     = 1'b0;
            cyc++;
            if (!rsp_valid_o && req_ready_o) busy_bad = 1'b1;
        end while (!rsp_valid_o && cyc < 60);
        insn = rsp_insn_o;
        f    = rsp_fault_o;
        nrd  = reads - r0;
        chk("R10 ready low while busy", 32'(busy_bad), 32'h0);
        chk("R11 response seen", 32'(rsp_valid_o), 32'h1);
        @(negedge clk);
        chk("R11 single pulse", 32'(rsp_valid_o), 32'h0);
    endtask

    function automatic logic [31:0] expect_insn(input logic [31:0] a, input logic cm);
        logic [15:0] lo;
        if (cm && a[1:0] == 2'b10) begin
            if (flt(a)) return 32'h0;
            lo = hw(a);
            if (lo[1:0] != 2'b11) return {16'h0, lo};
            if (flt(a + 32'd2)) return 32'h0;
            return {hw(a + 32'd2), lo};
        end
        if (flt(a)) return 32'h0;
        return wd(a);
    endfunction

    typedef struct packed {
        logic [31:0] addr;
        logic        cm;
        logic [1:0]  nrd;
        logic        f;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{32'h100, 1'b0, 2'd1, 1'b0},   // R3 cold miss
        '{32'h100, 1'b0, 2'd0, 1'b0},   // R2 hit
        '{32'h102, 1'b0, 2'd1, 1'b0},   // R4 offset 2, mode off: cache path, same line
        '{32'h100, 1'b0, 2'd1, 1'b0},   // R3 evicted by full-address tag
        '{32'h102, 1'b1, 2'd2, 1'b0},   // R6 split, wide
        '{32'h112, 1'b1, 2'd1, 1'b0},   // R5 split, compressed
        '{32'h100, 1'b1, 2'd0, 1'b0},   // R4 aligned with mode on: cache hit
        '{32'h202, 1'b1, 2'd2, 1'b0},   // R6 split, wide
        '{32'h202, 1'b0, 2'd1, 1'b0},   // R7 split did not fill
        '{32'h202, 1'b0, 2'd0, 1'b0},   // R2 now hit
        '{32'h500, 1'b0, 2'd1, 1'b0},   // R3 alias of line 0x40
        '{32'h100, 1'b0, 2'd1, 1'b0},   // R3 evicted by alias
        '{32'h3FC, 1'b0, 2'd1, 1'b0},   // R3 last line
        '{32'h3FC, 1'b0, 2'd0, 1'b0},   // R2 last line hit
        '{32'hC00, 1'b0, 2'd1, 1'b1},   // R8 word fault
        '{32'hC00, 1'b0, 2'd1, 1'b1},   // R8 fault not filled
        '{32'hBFE, 1'b1, 2'd2, 1'b1},   // R8 second half faults
        '{32'hC02, 1'b1, 2'd1, 1'b1},   // R8 first half faults, no second read
        '{32'h116, 1'b1, 2'd1, 1'b0}    // R5 compressed
    };

    initial begin
        logic [31:0] insn;
        logic f;
        int cyc;
        int nrd;
        logic [31:0] old;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready in reset", 32'(req_ready_o), 32'h1);
        chk("R1 rsp idle in reset", 32'(rsp_valid_o), 32'h0);
        chk("R1 mem idle in reset", 32'(mem_req_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready_o), 32'h1);
        chk("R1 mem idle after reset", 32'(mem_req_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            fetch(VEC[i].addr, VEC[i].cm, 1'b0, insn, f, cyc, nrd);
            chk("R3 R5 R6 R7 read count", 32'(nrd), 32'(VEC[i].nrd));
            chk("R8 fault flag", 32'(f), 32'(VEC[i].f));
            chk("R2 R3 R5 R6 R8 insn", insn, expect_insn(VEC[i].addr, VEC[i].cm));
            if (VEC[i].nrd == 2'd0) chk("R2 hit latency", 32'(cyc), 32'h1);
        end

        // R2: a hit is served from the cache even after memory changes
        fetch(32'h600, 1'b0, 1'b0, insn, f, cyc, nrd);
        old = wd(32'h600);
        salt = 14'h2B3;
        fetch(32'h600, 1'b0, 1'b0, insn, f, cyc, nrd);
        chk("R2 hit no read", 32'(nrd), 32'h0);
        chk("R2 hit returns cached word", insn, old);

        // R9: separate flush cycle
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        fetch(32'h600, 1'b0, 1'b0, insn, f, cyc, nrd);
        chk("R9 miss after flush", 32'(nrd), 32'h1);
        chk("R9 refetched word", insn, wd(32'h600));
        fetch(32'h3FC, 1'b0, 1'b0, insn, f, cyc, nrd);
        chk("R9 other line also flushed", 32'(nrd), 32'h1);

        // R9: flush in the cycle of a lookup
        fetch(32'h600, 1'b0, 1'b1, insn, f, cyc, nrd);
        chk("R9 same-cycle flush misses", 32'(nrd), 32'h1);
        fetch(32'h600, 1'b0, 1'b0, insn, f, cyc, nrd);
        chk("R9 refilled line hits", 32'(nrd), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule